// File: doc/BRIEF.md
# MMIO console register interface

This block is the register front end of a memory-mapped console peripheral. It sits on a 32-bit slave register bus with word-sized accesses. A host can send one character at a time through a transmit offset. It can read how many received bytes are waiting, program a 64-bit buffer address and a transfer length, and issue commands. Received serial bytes arrive on a valid/ready input and go into a parameterised receive FIFO. That input is only ready while the FIFO has a free slot.

One level-sensitive interrupt line tells the host that received bytes are waiting. Two commands turn it on and off; there is no separate mask register. Two further commands hand a block move to an external transfer engine, which runs it from the programmed address and length. Those two commands use a start/busy handshake. The engine drains the receive FIFO through a pop port that shows the oldest byte. The bus access is a select held by the master until the block answers with a ready. The block holds that ready low while a character is waiting for the transmit sink, or while a transfer command finds the engine busy.

Top module: `console_regif`

## Requirements
- R1: After reset the receive FIFO is empty (pending count reads 0, rxReady is 1), interrupts are disabled (irq is 0), and xferPtr and xferLen are both 0.
- R2: A read at offset 0x20 returns 32'h1. A read at any offset other than 0x04 and 0x20 returns 0, including the write-only offsets and offsets at or beyond 0x24.
- R3: A read at offset 0x04 returns the number of bytes held in the receive FIFO, zero-extended to 32 bits.
- R4: A byte on rxData is stored only when rxValid and rxReady are both 1 on a clock edge. rxReady is 1 exactly while the FIFO holds fewer than DEPTH bytes. A byte offered while the FIFO is full is dropped and leaves the count unchanged.
- R5: engPopData shows the oldest stored byte. A cycle with engPop high and the FIFO non-empty removes that byte, so bytes leave in arrival order.
- R6: A write at offset 0x00 drives busWdata[7:0] on txData with txValid high. busReady stays 0 until txReady is 1, so exactly one byte is handed over per write.
- R7: A write at offset 0x10 sets xferPtr to {32'h0, data}, which clears the upper half. A write at offset 0x18 replaces xferPtr[63:32] and keeps xferPtr[31:0].
- R8: A write at offset 0x14 sets xferLen to the written word.
- R9: irq is 1 exactly when interrupts are enabled and the FIFO is non-empty. Writing command word 1 at offset 0x08 enables interrupts and writing 0 disables them; either takes effect on the cycle after the write.
- R10: Command words 2 and 3 at offset 0x08 pulse xferStart for the completing cycle, with xferDir 0 for word 2 (memory to output) and 1 for word 3 (FIFO to memory). While xferBusy is 1 the write is stalled with busReady 0 and xferStart 0.
- R11: Writes to offsets 0x04, 0x0C and 0x20, and command words other than 0 to 3, change no state and raise no xferStart or txValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access request, held until busReady |
| busWrite | input | 1 | 1 write, 0 read |
| busAddr | input | ADDR_W | Byte offset of the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busReady |
| busReady | output | 1 | Access completes on this edge |
| txData | output | 8 | Character to send |
| txValid | output | 1 | Character offered |
| txReady | input | 1 | Sink accepts the character |
| rxData | input | 8 | Incoming byte |
| rxValid | input | 1 | Incoming byte offered |
| rxReady | output | 1 | FIFO has a free slot |
| engPop | input | 1 | Transfer engine removes the oldest byte |
| engPopData | output | 8 | Oldest byte in the FIFO |
| xferStart | output | 1 | Start pulse for the transfer engine |
| xferDir | output | 1 | 0 memory to output, 1 FIFO to memory |
| xferPtr | output | 64 | Buffer address |
| xferLen | output | 32 | Transfer length |
| xferBusy | input | 1 | Transfer engine is busy |
| irq | output | 1 | Level interrupt, bytes pending |

## Verification
The bench fills the FIFO past its depth and then drains it in order. A design with an off-by-one full flag would either lose the last byte or accept a ninth. Storing a dropped byte would show up as a wrong count or an out-of-order pop. The bench also writes the low pointer word after the high one, and a design that merged the halves instead of clearing the upper word would keep a stale upper half. It enables interrupts with bytes already waiting and also with an empty FIFO. It stalls both the transmit sink and the transfer engine, where a wrong design would complete a bus access early, pulse the start twice or lose a character. Writes to read-only and undecoded offsets, and unknown command words, are followed by reads and output checks that would expose any stray state change.

// File: rtl/console_pkg.sv
package console_pkg;
  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 64;

  localparam int OFF_TX      = 'h00;
  localparam int OFF_PENDING = 'h04;
  localparam int OFF_CMD     = 'h08;
  localparam int OFF_PTR_LO  = 'h10;
  localparam int OFF_LEN     = 'h14;
  localparam int OFF_PTR_HI  = 'h18;
  localparam int OFF_VERSION = 'h20;

  localparam logic [REG_W-1:0] VERSION_ID = 32'd1;

  localparam logic [REG_W-1:0] CMD_IRQ_OFF = 32'd0;
  localparam logic [REG_W-1:0] CMD_IRQ_ON  = 32'd1;
  localparam logic [REG_W-1:0] CMD_MEM_OUT = 32'd2;
  localparam logic [REG_W-1:0] CMD_RX_MEM  = 32'd3;

  typedef struct packed {
    logic             ldPtrLo;
    logic             ldPtrHi;
    logic             ldLen;
    logic             irqOn;
    logic             irqOff;
    logic [REG_W-1:0] wdata;
  } ctrlStrobes_t;
endpackage

// File: rtl/console_rxfifo.sv
module console_rxfifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  output logic              pushReady,
  input  logic              pop,
  output logic [DATA_W-1:0] headData,
  output logic [CNT_W-1:0]  count
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [IDX_W-1:0]  wrIdx, rdIdx;
  logic              pushOk, popOk;

  assign pushReady = (count != CNT_W'(DEPTH));
  assign pushOk    = pushValid & pushReady;
  assign popOk     = pop & (count != '0);
  assign headData  = store[rdIdx];

  always_ff @(posedge clk) begin
    if (pushOk) store[wrIdx] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrIdx <= (wrIdx == LAST_IDX) ? '0 : wrIdx + 1'b1;
      if (popOk)  rdIdx <= (rdIdx == LAST_IDX) ? '0 : rdIdx + 1'b1;
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/console_ctrl.sv
module console_ctrl
  import console_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 4
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  output logic              busReady,
  input  logic [CNT_W-1:0]  pendCount,
  output logic [BYTE_W-1:0] txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              xferStart,
  output logic              xferDir,
  input  logic              xferBusy,
  output ctrlStrobes_t      strobes
);
  logic wrAcc, rdAcc, isCmd, cmdXfer, stall;

  always_comb begin
    wrAcc   = busSel & busWrite;
    rdAcc   = busSel & ~busWrite;
    isCmd   = wrAcc & (busAddr == ADDR_W'(OFF_CMD));
    cmdXfer = isCmd & ((busWdata == CMD_MEM_OUT) | (busWdata == CMD_RX_MEM));

    txValid = wrAcc & (busAddr == ADDR_W'(OFF_TX));
    txData  = busWdata[BYTE_W-1:0];

    stall    = (txValid & ~txReady) | (cmdXfer & xferBusy);
    busReady = busSel & ~stall;

    xferStart = cmdXfer & ~xferBusy;
    xferDir   = (busWdata == CMD_RX_MEM);

    strobes.ldPtrLo = wrAcc & (busAddr == ADDR_W'(OFF_PTR_LO));
    strobes.ldPtrHi = wrAcc & (busAddr == ADDR_W'(OFF_PTR_HI));
    strobes.ldLen   = wrAcc & (busAddr == ADDR_W'(OFF_LEN));
    strobes.irqOn   = isCmd & (busWdata == CMD_IRQ_ON);
    strobes.irqOff  = isCmd & (busWdata == CMD_IRQ_OFF);
    strobes.wdata   = busWdata;

    busRdata = '0;
    if (rdAcc && busAddr == ADDR_W'(OFF_PENDING)) busRdata = REG_W'(pendCount);
    else if (rdAcc && busAddr == ADDR_W'(OFF_VERSION)) busRdata = VERSION_ID;
  end
endmodule

// File: rtl/console_dp.sv
module console_dp
  import console_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic              engPop,
  output logic [BYTE_W-1:0] engPopData,
  output logic [CNT_W-1:0]  pendCount,
  output logic [PTR_W-1:0]  xferPtr,
  output logic [REG_W-1:0]  xferLen,
  output logic              irq
);
  logic irqEnabled;

  console_rxfifo #(.DEPTH(DEPTH), .DATA_W(BYTE_W), .CNT_W(CNT_W)) u_rxfifo (
    .clk      (clk),
    .rstN     (rstN),
    .pushValid(rxValid),
    .pushData (rxData),
    .pushReady(rxReady),
    .pop      (engPop),
    .headData (engPopData),
    .count    (pendCount)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferPtr    <= '0;
      xferLen    <= '0;
      irqEnabled <= 1'b0;
    end else begin
      if (strobes.ldPtrLo)      xferPtr <= {{(PTR_W-REG_W){1'b0}}, strobes.wdata};
      else if (strobes.ldPtrHi) xferPtr[PTR_W-1:REG_W] <= strobes.wdata;
      if (strobes.ldLen)        xferLen <= strobes.wdata;
      if (strobes.irqOn)        irqEnabled <= 1'b1;
      else if (strobes.irqOff)  irqEnabled <= 1'b0;
    end
  end

  assign irq = irqEnabled & (pendCount != '0);
endmodule

// File: rtl/console_regif.sv
module console_regif
  import console_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busReady,
  output logic [7:0]        txData,
  output logic              txValid,
  input  logic              txReady,
  input  logic [7:0]        rxData,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic              engPop,
  output logic [7:0]        engPopData,
  output logic              xferStart,
  output logic              xferDir,
  output logic [63:0]       xferPtr,
  output logic [31:0]       xferLen,
  input  logic              xferBusy,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  ctrlStrobes_t     strobes;
  logic [CNT_W-1:0] pendCount;

  console_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .busReady (busReady),
    .pendCount(pendCount),
    .txData   (txData),
    .txValid  (txValid),
    .txReady  (txReady),
    .xferStart(xferStart),
    .xferDir  (xferDir),
    .xferBusy (xferBusy),
    .strobes  (strobes)
  );

  console_dp #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rxData    (rxData),
    .rxValid   (rxValid),
    .rxReady   (rxReady),
    .engPop    (engPop),
    .engPopData(engPopData),
    .pendCount (pendCount),
    .xferPtr   (xferPtr),
    .xferLen   (xferLen),
    .irq       (irq)
  );
endmodule

// File: rtl/console_regif_chk.sv
module console_regif_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxValid,
  input logic             rxReady,
  input logic             engPop,
  input logic [CNT_W-1:0] pendCount,
  input logic             txValid,
  input logic             txReady,
  input logic             busReady,
  input logic             xferStart,
  input logic             xferBusy,
  input logic             irq
);
  p_irq_needs_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (pendCount != '0));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !engPop) |=> (pendCount == $past(pendCount)));

  p_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount == CNT_W'(DEPTH)) |-> !rxReady);

  p_push_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxReady && !engPop) |=> (pendCount == CNT_W'($past(pendCount) + 1'b1)));

  p_tx_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |-> !busReady);

  p_start_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> (!xferBusy && busReady));
endmodule

bind console_regif console_regif_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rxValid  (rxValid),
  .rxReady  (rxReady),
  .engPop   (engPop),
  .pendCount(pendCount),
  .txValid  (txValid),
  .txReady  (txReady),
  .busReady (busReady),
  .xferStart(xferStart),
  .xferBusy (xferBusy),
  .irq      (irq)
);

// File: tb/test_console_regif.sv
module test_console_regif;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic busReady;
  logic [7:0] txData;
  logic txValid;
  logic txReady = 1'b1;
  logic [7:0] rxData = '0;
  logic rxValid = 1'b0;
  logic rxReady;
  logic engPop = 1'b0;
  logic [7:0] engPopData;
  logic xferStart, xferDir;
  logic [63:0] xferPtr;
  logic [31:0] xferLen;
  logic xferBusy = 1'b0;
  logic irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int startCount = 0;
  logic [7:0] txExp[$];
  logic [7:0] rxExp[$];
  logic       dirExp[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  console_regif #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_console_regif (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitors: compare design output against scoreboard queues
  always @(negedge clk) begin
    if (rstN && txValid && txReady) begin
      if (txExp.size() == 0) check("R6 unexpected tx byte", 64'(txData), 64'hx);
      else check("R6 tx byte", 64'(txData), 64'(txExp.pop_front()));
    end
    if (rstN && engPop && rxExp.size() > 0)
      check("R5 pop order", 64'(engPopData), 64'(rxExp.pop_front()));
    if (rstN && xferStart) begin
      startCount++;
      if (dirExp.size() == 0) check("R10 unexpected start", 64'(xferStart), 64'h0);
      else check("R10 start dir", 64'(xferDir), 64'(dirExp.pop_front()));
    end
  end

  task automatic busWr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    do @(negedge clk); while (!busReady);
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    do @(negedge clk); while (!busReady);
    d = busRdata;
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic rxSend(input logic [7:0] b);
    @(posedge clk); #1;
    rxValid = 1'b1; rxData = b;
    @(negedge clk);
    check("R4 rxReady vs free space", 64'(rxReady), 64'(rxExp.size() < DEPTH));
    if (rxReady) rxExp.push_back(b);
    @(posedge clk); #1;
    rxValid = 1'b0;
  endtask

  task automatic popOne();
    @(posedge clk); #1;
    engPop = 1'b1;
    @(posedge clk); #1;
    engPop = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 irq", 64'(irq), 64'h0);
    check("R1 rxReady", 64'(rxReady), 64'h1);
    check("R1 ptr", xferPtr, 64'h0);
    check("R1 len", 64'(xferLen), 64'h0);
    busRd(6'h04, rd); check("R1 pending", 64'(rd), 64'h0);

    // R2 version and undecoded reads
    busRd(6'h20, rd); check("R2 version", 64'(rd), 64'h1);
    busRd(6'h24, rd); check("R2 beyond window", 64'(rd), 64'h0);
    busRd(6'h1C, rd); check("R2 hole", 64'(rd), 64'h0);
    busRd(6'h10, rd); check("R2 write-only ptr", 64'(rd), 64'h0);
    busRd(6'h00, rd); check("R2 write-only tx", 64'(rd), 64'h0);

    // R6 transmit, no stall then stall
    txExp.push_back(8'hA5);
    busWr(6'h00, 32'h1234_56A5);
    @(posedge clk); #1;
    txReady = 1'b0;
    busSel = 1'b1; busWrite = 1'b1; busAddr = 6'h00; busWdata = 32'h0000_003C;
    txExp.push_back(8'h3C);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R6 stall busReady", 64'(busReady), 64'h0);
      check("R6 stall txValid", 64'(txValid), 64'h1);
    end
    @(posedge clk); #1 txReady = 1'b1;
    @(negedge clk); check("R6 release busReady", 64'(busReady), 64'h1);
    @(posedge clk); #1 busSel = 1'b0; busWrite = 1'b0;
    @(negedge clk); check("R6 all bytes sent", 64'(txExp.size()), 64'h0);

    // R7 / R8 pointer and length
    busWr(6'h10, 32'h1234_5678); @(negedge clk);
    check("R7 low load", xferPtr, 64'h0000_0000_1234_5678);
    busWr(6'h18, 32'hAABB_CCDD); @(negedge clk);
    check("R7 high keeps low", xferPtr, 64'hAABB_CCDD_1234_5678);
    busWr(6'h10, 32'h0000_0011); @(negedge clk);
    check("R7 low clears high", xferPtr, 64'h0000_0000_0000_0011);
    busWr(6'h18, 32'h0000_0002); @(negedge clk);
    check("R7 high again", xferPtr, 64'h0000_0002_0000_0011);
    busWr(6'h14, 32'h0000_0040); @(negedge clk);
    check("R8 length", 64'(xferLen), 64'h40);

    // R10 transfer commands
    dirExp.push_back(1'b0); busWr(6'h08, 32'd2);
    dirExp.push_back(1'b1); busWr(6'h08, 32'd3);
    @(negedge clk); check("R10 two starts", 64'(startCount), 64'd2);
    @(posedge clk); #1;
    xferBusy = 1'b1;
    busSel = 1'b1; busWrite = 1'b1; busAddr = 6'h08; busWdata = 32'd2;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 busy stall busReady", 64'(busReady), 64'h0);
      check("R10 busy no start", 64'(xferStart), 64'h0);
    end
    @(posedge clk); #1 xferBusy = 1'b0; dirExp.push_back(1'b0);
    @(negedge clk); check("R10 start after busy", 64'(xferStart), 64'h1);
    @(posedge clk); #1 busSel = 1'b0; busWrite = 1'b0;
    @(negedge clk); check("R10 three starts", 64'(startCount), 64'd3);

    // R4 / R3 / R9 receive fill with interrupts disabled
    for (int i = 0; i < DEPTH + 2; i++) rxSend(8'h40 + 8'(i));
    busRd(6'h04, rd); check("R3 pending full", 64'(rd), 64'(DEPTH));
    check("R4 full rxReady", 64'(rxReady), 64'h0);
    check("R9 irq while disabled", 64'(irq), 64'h0);

    // R11 ignored writes and unknown commands
    busWr(6'h04, 32'hFF); busWr(6'h20, 32'h5); busWr(6'h0C, 32'hDEAD_BEEF);
    busWr(6'h08, 32'd7); busWr(6'h08, 32'h101);
    busRd(6'h04, rd); check("R11 pending untouched", 64'(rd), 64'(DEPTH));
    busRd(6'h20, rd); check("R11 version untouched", 64'(rd), 64'h1);
    check("R11 ptr untouched", xferPtr, 64'h0000_0002_0000_0011);
    check("R11 len untouched", 64'(xferLen), 64'h40);
    check("R11 no stray start", 64'(startCount), 64'd3);
    check("R11 irq still off", 64'(irq), 64'h0);

    // R9 enable with bytes pending, then disable
    busWr(6'h08, 32'd1); @(negedge clk);
    check("R9 enable raises irq", 64'(irq), 64'h1);
    busWr(6'h08, 32'd0); @(negedge clk);
    check("R9 disable drops irq", 64'(irq), 64'h0);
    busWr(6'h08, 32'd1);

    // R5 drain in order, then R3 partial count
    for (int i = 0; i < 3; i++) popOne();
    busRd(6'h04, rd); check("R3 pending after pops", 64'(rd), 64'(DEPTH - 3));
    check("R4 ready after pop", 64'(rxReady), 64'h1);
    while (rxExp.size() > 0) popOne();
    @(negedge clk);
    check("R9 irq drops when empty", 64'(irq), 64'h0);
    busRd(6'h04, rd); check("R3 pending empty", 64'(rd), 64'h0);

    // R9 enabled but empty, then a byte arrives
    rxSend(8'h77);
    @(negedge clk); check("R9 irq on arrival", 64'(irq), 64'h1);
    popOne();
    @(negedge clk); check("R9 irq after last pop", 64'(irq), 64'h0);
    check("R5 queue drained", 64'(rxExp.size()), 64'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule